// File: doc/BRIEF.md
# Byte Serial Port with Master-Conflict Protection

This block is a byte-wide serial peripheral port that can run as bus master or as a selected slave. Software drives it through three registers on a simple synchronous read/write strobe bus: control, status and data. As master it generates the serial clock from the system clock through a fixed divider. As slave it follows an external serial clock while its select input is held low. Data moves most significant bit first. Bits are sampled on the rising serial-clock edge and change on the falling edge, with the clock idling low.

Every finished byte is copied into a one-byte receive buffer and raises a completion flag. If a second byte finishes before software clears that flag, the buffer keeps the first byte and the later one is lost. A master that sees its select input pulled low takes this as a conflict with another master. It raises a fault flag, drops its enable and master bits and releases every output it drives. Both flags clear only through a two-step sequence: a status read that sees the flag set, then a specific register access.

Top module: `sbp_port`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read as zero, irq is low, and sck_oe, mosi_oe and miso_oe are low.
- R2: While control bit 1 (enable) and bit 2 (master) are both set and ss_n_i is low, the fault flag (status bit 1) becomes set. Enable and master are forced to zero, and sck_oe and mosi_oe go low.
- R3: irq is high exactly when control bit 0 (interrupt enable) is set and either the completion flag (status bit 0) or the fault flag is set.
- R4: The fault flag clears only when a status read that sees it set is followed by a control write. That write may set enable and master again.
- R5: While the fault flag is set, a control write that does not complete the clearing sequence leaves enable and master at zero. The interrupt-enable bit is still written.
- R6: In master mode a data write (address 2) starts a transfer. Eight bits go out on mosi_o, MSB first. Each sck_o half period lasts DIV clock cycles. In slave mode a data write only loads the shift register and produces no sck_o activity.
- R7: At the end of each byte the completion flag is set in both master and slave mode. On the same cycle the received byte goes into the receive buffer. Data reads return that buffer.
- R8: The completion flag clears only when a status read that sees it set is followed by a data read or a data write. A data read without that status read leaves the flag set.
- R9: When a byte finishes while the completion flag is still set, the receive buffer keeps the earlier byte.
- R10: In slave mode with ss_n_i low, the port shifts a byte on sck_i. It samples mosi_i and presents its loaded byte on miso_o, MSB first. miso_oe is high only while enabled, in slave mode and selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the strobe cycle |
| irq | output | 1 | Interrupt request |
| ss_n_i | input | 1 | Select input, active low |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe | output | 1 | Serial data output enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | Serial data output enable (slave) |

## Verification
The bench builds the port with DW=8 and DIV=2. A master byte then takes only 32 clock cycles, which leaves room for a long run of random master transfers, back-to-back overrun pairs and the fault and clearing sequences within the cycle budget. The slave serial clock is driven much slower than the system clock, so the input synchronizer latency is covered and miso_o can be sampled at settled points.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef struct packed {
        logic mst;
        logic en;
        logic ie;
    } ctl_t;

    typedef struct packed {
        logic fault;
        logic done;
    } flags_t;

    function automatic ctl_t ctl_from_word(input logic [2:0] w);
        ctl_t c;
        c.ie  = w[0];
        c.en  = w[1];
        c.mst = w[2];
        return c;
    endfunction
endpackage

// File: rtl/sbp_shifter.sv
module sbp_shifter #(
    parameter int DW  = 8,
    parameter int DIV = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          mst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          ss_n_i,
    input  logic          sck_i,
    input  logic          mosi_i,
    input  logic          miso_i,
    output logic          sck_o,
    output logic          ser_out,
    output logic          done_p,
    output logic [DW-1:0] rx_byte
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);
    localparam logic [DCW-1:0] DLAST = DCW'(DIV - 1);

    logic [DW-1:0]  sreg;
    logic [CW-1:0]  bitcnt;
    logic [DCW-1:0] divcnt;
    logic           busy, sck_q, in_bit;
    logic [1:0]     sck_sync, mosi_sync;
    logic           sck_prev;
    logic           master_on, slave_on, tick;
    logic           samp_edge, shift_edge;

    assign master_on = en && mst;
    assign slave_on  = en && !mst && !ss_n_i;
    assign tick      = busy && (divcnt == DLAST);

    always_comb begin
        if (master_on) begin
            samp_edge  = tick && !sck_q;
            shift_edge = tick && sck_q;
        end else if (slave_on) begin
            samp_edge  = sck_sync[1] && !sck_prev;
            shift_edge = !sck_sync[1] && sck_prev;
        end else begin
            samp_edge  = 1'b0;
            shift_edge = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sync  <= '0;
            mosi_sync <= '0;
            sck_prev  <= 1'b0;
        end else begin
            sck_sync  <= {sck_sync[0], sck_i};
            mosi_sync <= {mosi_sync[0], mosi_i};
            sck_prev  <= sck_sync[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '0;
            bitcnt  <= '0;
            divcnt  <= '0;
            busy    <= 1'b0;
            sck_q   <= 1'b0;
            in_bit  <= 1'b0;
            done_p  <= 1'b0;
            rx_byte <= '0;
        end else begin
            done_p <= 1'b0;
            if (!master_on) begin
                busy   <= 1'b0;
                sck_q  <= 1'b0;
                divcnt <= '0;
            end
            if (!master_on && !slave_on) begin
                bitcnt <= '0;
            end
            if (load && !busy) begin
                sreg <= load_data;
                if (master_on) begin
                    busy   <= 1'b1;
                    divcnt <= '0;
                    bitcnt <= '0;
                end
            end else begin
                if (busy && master_on) begin
                    divcnt <= tick ? '0 : divcnt + 1'b1;
                    if (tick) sck_q <= !sck_q;
                end
                if (samp_edge) begin
                    in_bit <= master_on ? miso_i : mosi_sync[1];
                end
                if (shift_edge) begin
                    sreg   <= {sreg[DW-2:0], in_bit};
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == LAST) begin
                        bitcnt  <= '0;
                        done_p  <= 1'b1;
                        rx_byte <= {sreg[DW-2:0], in_bit};
                        if (master_on) busy <= 1'b0;
                    end
                end
            end
        end
    end

    assign sck_o   = sck_q;
    assign ser_out = sreg[DW-1];

    // R6
    master_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done_p && $past(master_on)) |-> $past(busy));

    // R6
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> !sck_o);
endmodule

// File: rtl/sbp_regs.sv
module sbp_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ss_n_i,
    input  logic          done_p,
    input  logic [DW-1:0] rx_byte,
    output sbp_pkg::ctl_t ctl,
    output logic          data_load,
    output logic          irq
);
    import sbp_pkg::*;

    flags_t        flg;
    logic          done_armed, fault_armed;
    logic [DW-1:0] rx_buf;
    logic          stat_rd, ctl_wr, data_acc, fault_hit;
    ctl_t          ctl_new;
    logic          unused_wbits;

    assign stat_rd   = bus_rd && bus_addr == ADDR_STAT;
    assign ctl_wr    = bus_wr && bus_addr == ADDR_CTL;
    assign data_acc  = (bus_rd || bus_wr) && bus_addr == ADDR_DATA;
    assign data_load = bus_wr && bus_addr == ADDR_DATA;
    assign fault_hit = ctl.en && ctl.mst && !ss_n_i;
    assign ctl_new   = ctl_from_word(bus_wdata[2:0]);
    assign unused_wbits = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl         <= '0;
            flg         <= '0;
            done_armed  <= 1'b0;
            fault_armed <= 1'b0;
            rx_buf      <= '0;
        end else begin
            if (stat_rd && flg.done)  done_armed  <= 1'b1;
            if (stat_rd && flg.fault) fault_armed <= 1'b1;

            if (ctl_wr) begin
                ctl.ie <= ctl_new.ie;
                if (!flg.fault || fault_armed) begin
                    ctl.en  <= ctl_new.en;
                    ctl.mst <= ctl_new.mst;
                end else begin
                    ctl.en  <= 1'b0;
                    ctl.mst <= 1'b0;
                end
                if (flg.fault && fault_armed) begin
                    flg.fault   <= 1'b0;
                    fault_armed <= 1'b0;
                end
            end

            if (data_acc && done_armed) begin
                flg.done   <= 1'b0;
                done_armed <= 1'b0;
            end

            if (done_p && !(flg.done && !(data_acc && done_armed))) begin
                flg.done <= 1'b1;
                rx_buf   <= rx_byte;
            end

            if (fault_hit) begin
                flg.fault   <= 1'b1;
                fault_armed <= 1'b0;
                ctl.en      <= 1'b0;
                ctl.mst     <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_CTL:  bus_rdata[2:0] = ctl;
                ADDR_STAT: bus_rdata[1:0] = flg;
                ADDR_DATA: bus_rdata      = rx_buf;
                default:   bus_rdata      = '0;
            endcase
        end
    end

    assign irq = ctl.ie && (flg.done || flg.fault);

    // R2 R5
    fault_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
        flg.fault |-> (!ctl.en && !ctl.mst));

    // R9
    rxbuf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flg.done && $past(flg.done)) |-> (rx_buf == $past(rx_buf)));

    // R8
    done_clear_seq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flg.done) |-> $past(done_armed));

    // R4
    fault_clear_seq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flg.fault) |-> ($past(fault_armed) && $past(ctl_wr)));
endmodule

// File: rtl/sbp_port.sv
module sbp_port #(
    parameter int DW  = 8,
    parameter int DIV = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    input  logic          ss_n_i,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe
);
    import sbp_pkg::*;

    ctl_t          ctl;
    logic          data_load, done_p, ser_out;
    logic [DW-1:0] rx_byte;

    sbp_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ss_n_i(ss_n_i), .done_p(done_p), .rx_byte(rx_byte),
        .ctl(ctl), .data_load(data_load), .irq(irq)
    );

    sbp_shifter #(.DW(DW), .DIV(DIV)) u_shift (
        .clk(clk), .rst(rst),
        .en(ctl.en), .mst(ctl.mst),
        .load(data_load), .load_data(bus_wdata),
        .ss_n_i(ss_n_i), .sck_i(sck_i), .mosi_i(mosi_i), .miso_i(miso_i),
        .sck_o(sck_o), .ser_out(ser_out),
        .done_p(done_p), .rx_byte(rx_byte)
    );

    assign sck_oe  = ctl.en && ctl.mst;
    assign mosi_oe = ctl.en && ctl.mst;
    assign mosi_o  = ser_out;
    assign miso_o  = ser_out;
    assign miso_oe = ctl.en && !ctl.mst && !ss_n_i;

    // R10
    single_driver_chk: assert property (@(posedge clk) disable iff (rst)
        !(miso_oe && mosi_oe));
endmodule

// File: tb/sim_sbp_port.sv
module sim_sbp_port;
    localparam int DW = 8;
    localparam int DIV = 2;
    localparam int XFER = 16 * DIV + 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic irq, ss_n_i, sck_i, mosi_i, miso_i;
    logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] m_tx, m_rx;

    always #4 clk = ~clk;

    sbp_port #(.DW(DW), .DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .ss_n_i(ss_n_i), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
    );

    // remote slave model for master transfers, mode 0, MSB first
    assign miso_i = m_tx[DW-1];
    always @(posedge sck_o) m_rx = {m_rx[DW-2:0], mosi_o};
    always @(negedge sck_o) m_tx = {m_tx[DW-2:0], 1'b0};

    function automatic logic [7:0] exp_stat(input logic fault, input logic done);
        return {6'b0, fault, done};
    endfunction

    function automatic logic exp_irq(input logic ie, input logic fault, input logic done);
        return ie && (fault || done);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic master_xfer(input logic [DW-1:0] out_b, input logic [DW-1:0] in_b);
        m_tx = in_b; m_rx = '0;
        wr(2'd2, out_b);
        idle(XFER);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d, a, b, tx, mb, sl_out;
        ss_n_i = 1'b1; sck_i = 1'b0; mosi_i = 1'b0; m_tx = '0; m_rx = '0;
        void'($urandom(32'd1234));
        idle(4);
        rst = 1'b0;
        idle(2);

        // R1 reset state
        rd(2'd0, d); chk("R1 ctl", d, 0);
        rd(2'd1, d); chk("R1 stat", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 oe", {sck_oe, mosi_oe, miso_oe}, 0);

        // master mode, random transfers
        wr(2'd0, 8'h06);
        chk("R6 oe master", {sck_oe, mosi_oe}, 2'b11);
        for (int i = 0; i < 16; i++) begin
            a = 8'($urandom); b = 8'($urandom);
            master_xfer(a, b);
            chk("R6 mosi byte", m_rx, a);
            chk("R3 irq off", irq, exp_irq(1'b0, 1'b0, 1'b1));
            rd(2'd2, d); chk("R7 rx data", d, b);
            rd(2'd1, d); chk("R8 stat before data read", d, exp_stat(0, 1));
            rd(2'd2, d);
            rd(2'd1, d); chk("R8 stat cleared", d, exp_stat(0, 0));
        end

        // R8 data read without status read does not clear
        master_xfer(8'h11, 8'h5A);
        rd(2'd2, d);
        rd(2'd1, d); chk("R8 no-arm keep", d, exp_stat(0, 1));
        wr(2'd2, 8'h00);
        idle(2);
        rd(2'd1, d); chk("R8 clear by write", d, exp_stat(0, 0));
        idle(XFER);
        rd(2'd1, d); rd(2'd2, d);

        // R9 overrun keeps first byte; R3 irq on done
        wr(2'd0, 8'h07);
        master_xfer(8'hC3, 8'hA5);
        chk("R3 irq done", irq, exp_irq(1'b1, 1'b0, 1'b1));
        master_xfer(8'h3C, 8'h96);
        rd(2'd2, d); chk("R9 overrun first kept", d, 8'hA5);
        rd(2'd1, d); rd(2'd2, d);
        chk("R3 irq clears", irq, 0);

        // R2 fault
        wr(2'd0, 8'h07);
        @(negedge clk); ss_n_i = 1'b0;
        idle(3);
        chk("R2 oe off", {sck_oe, mosi_oe}, 2'b00);
        chk("R3 irq fault", irq, 1);
        rd(2'd0, d); chk("R2 ctl forced", d, 8'h01);
        @(negedge clk); ss_n_i = 1'b1;
        // R5 plain write cannot restore
        wr(2'd0, 8'h07);
        rd(2'd0, d); chk("R5 ctl held off", d, 8'h01);
        wr(2'd0, 8'h06);
        rd(2'd0, d); chk("R5 ie still written", d, 8'h00);
        // R4 proper sequence
        rd(2'd1, d); chk("R4 fault visible", d, exp_stat(1, 0));
        wr(2'd0, 8'h07);
        rd(2'd0, d); chk("R4 ctl restored", d, 8'h07);
        rd(2'd1, d); chk("R4 fault cleared", d, exp_stat(0, 0));

        // R10 slave transfers
        wr(2'd0, 8'h02);
        chk("R10 miso idle", miso_oe, 0);
        for (int k = 0; k < 3; k++) begin
            tx = (k == 0) ? 8'h81 : 8'($urandom);
            mb = (k == 0) ? 8'h7E : 8'($urandom);
            wr(2'd2, tx);
            chk("R6 slave write no sck", sck_oe, 0);
            idle(4);
            rd(2'd1, d); chk("R6 slave write no xfer", d, exp_stat(0, 0));
            @(negedge clk); ss_n_i = 1'b0;
            idle(2);
            chk("R10 miso driven", miso_oe, 1);
            sl_out = '0;
            for (int j = DW - 1; j >= 0; j--) begin
                mosi_i = mb[j];
                idle(6);
                sl_out = {sl_out[DW-2:0], miso_o};
                sck_i = 1'b1;
                idle(6);
                sck_i = 1'b0;
            end
            idle(8);
            @(negedge clk); ss_n_i = 1'b1;
            idle(1);
            chk("R10 miso released", miso_oe, 0);
            chk("R10 miso byte", sl_out, tx);
            rd(2'd1, d); chk("R7 slave done", d, exp_stat(0, 1));
            rd(2'd2, d); chk("R10 slave rx", d, mb);
            rd(2'd1, d); chk("R8 slave clear", d, exp_stat(0, 0));
        end

        finish_run();
    end
endmodule